// File: doc/BRIEF.md
# Synchronous Memory Bus Master

This block runs single read and write transactions against a word-addressed memory over a synchronous bus with a wait-state handshake. One clock cycle is one bus state. A transaction always walks the same path: an idle state that puts the address on the bus, a first active state (T1) that raises the read or write strobe, and one or more wait-capable states (T2) that finish when the memory raises ready.

A requester offers an address, a direction, an instruction-fetch flag and write data. The request is taken in the cycle in which `req_valid` and `req_ready` are both high, and `req_ready` is high only while the controller is idle. When the transaction completes, `rsp_done` pulses for one cycle. On a read, the returned word is presented on `rsp_rdata` in that same cycle and is held there afterwards.

On the bus side the block drives the address, the read, write and fetch strobes, the write data and a data output enable. It samples `bus_ready` and `bus_rdata`. Every bus output is registered.

Top module: `mem_bus_ctrl`

## Requirements
- R1: After reset, `bus_rd`, `bus_wr`, `bus_fetch`, `bus_doe` and `rsp_done` are low, `bus_addr`, `bus_wdata` and `rsp_rdata` are zero, and `req_ready` is high.
- R2: `req_ready` is high only in the idle state. A request is accepted when `req_valid` is high in a cycle with `req_ready` high. `req_valid` and request fields that arrive while a transaction runs leave the bus outputs unchanged.
- R3: In the cycle after acceptance, `bus_addr` carries the request address while all strobes are low. The address then stays stable until the transaction completes.
- R4: On a read, `bus_rd` is high from T1 (two cycles after acceptance) through the completing T2, and `bus_wr` stays low the whole time.
- R5: On a read with `req_fetch` high, `bus_fetch` is high exactly while `bus_rd` is high. On a write, `req_fetch` is ignored and `bus_fetch` stays low.
- R6: On a write, `bus_wr` and `bus_doe` are high from T1 through the completing T2, and `bus_wdata` carries the request data in those cycles. `bus_wdata` is zero whenever `bus_doe` is low, and `bus_rd` stays low.
- R7: `bus_ready` is ignored in T1. In each T2, `bus_ready` low produces another T2, so a transaction with N low samples lasts N+1 T2 cycles.
- R8: `rsp_done` is high only in the completing T2, which is the T2 cycle with `bus_ready` high. On a read, `rsp_rdata` equals `bus_rdata` in that cycle and keeps that value until the next read completes. A write does not change `rsp_rdata`.
- R9: In the cycle after completion, all strobes and `bus_doe` are low and `req_ready` is high. At least one idle cycle separates any two transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_addr | input | AW (32) | Word address |
| req_wdata | input | DW (32) | Data to write |
| req_ready | output | 1 | Controller idle, request can be taken |
| rsp_done | output | 1 | Transaction completes this cycle |
| rsp_rdata | output | DW (32) | Read result, held after completion |
| bus_addr | output | AW (32) | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_fetch | output | 1 | Read is an instruction fetch |
| bus_wdata | output | DW (32) | Write data toward memory |
| bus_doe | output | 1 | Write data output enable |
| bus_ready | input | 1 | Memory completion handshake |
| bus_rdata | input | DW (32) | Read data from memory |

## Verification
The bench targets wait-state counting: a controller that samples `bus_ready` in T1 would finish one cycle early, and one that miscounts T2 would pulse done at the wrong cycle. It issues fetch-flagged writes, which would leak onto `bus_fetch` if the flag were not qualified by direction. It also presents request traffic during T2, which would corrupt `bus_addr` or start a back-to-back transaction if acceptance were not limited to idle. After each write it checks that the held read result is unchanged, which catches a capture that is not gated by direction.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_T1   = 2'd2,
        ST_T2   = 2'd3
    } bus_state_e;
endpackage

// File: rtl/mbc_fsm.sv
module mbc_fsm
    import mbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       bus_ready,
    output logic       idle,
    output logic       accept,
    output logic       enter_t1,
    output logic       finish
);
    typedef struct packed {
        bus_state_e st;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        idle     = (r_q.st == ST_IDLE);
        accept   = idle && req_valid;
        enter_t1 = (r_q.st == ST_ADDR);
        finish   = (r_q.st == ST_T2) && bus_ready;
        unique case (r_q.st)
            ST_IDLE: if (req_valid) r_d.st = ST_ADDR;
            ST_ADDR: r_d.st = ST_T1;
            ST_T1:   r_d.st = ST_T2;
            ST_T2:   if (bus_ready) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.st <= ST_IDLE;
        else        r_q    <= r_d;
    end
endmodule

// File: rtl/mbc_bus_regs.sv
module mbc_bus_regs #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          enter_t1,
    input  logic          finish,
    input  logic          req_write,
    input  logic          req_fetch,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_fetch,
    output logic          bus_doe,
    output logic          op_write
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          is_wr;
        logic          is_fetch;
        logic          rd;
        logic          wr;
        logic          fetch;
        logic          doe;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.addr     = req_addr;
            r_d.wdata    = req_wdata;
            r_d.is_wr    = req_write;
            r_d.is_fetch = req_fetch && !req_write;
        end
        if (enter_t1) begin
            r_d.rd    = !r_q.is_wr;
            r_d.wr    = r_q.is_wr;
            r_d.fetch = r_q.is_fetch;
            r_d.doe   = r_q.is_wr;
        end
        if (finish) begin
            r_d.rd    = 1'b0;
            r_d.wr    = 1'b0;
            r_d.fetch = 1'b0;
            r_d.doe   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_addr  = r_q.addr;
    assign bus_wdata = r_q.wdata & {DW{r_q.doe}};
    assign bus_rd    = r_q.rd;
    assign bus_wr    = r_q.wr;
    assign bus_fetch = r_q.fetch;
    assign bus_doe   = r_q.doe;
    assign op_write  = r_q.is_wr;
endmodule

// File: rtl/mbc_rsp.sv
module mbc_rsp #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          finish,
    input  logic          op_write,
    input  logic [DW-1:0] bus_rdata,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata
);
    typedef struct packed {
        logic [DW-1:0] rdata;
    } rsp_t;

    rsp_t r_d, r_q;
    logic take;

    always_comb begin
        r_d  = r_q;
        take = finish && !op_write;
        if (take) r_d.rdata = bus_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_done  = finish;
    assign rsp_rdata = take ? bus_rdata : r_q.rdata;
endmodule

// File: rtl/mem_bus_ctrl.sv
module mem_bus_ctrl #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_fetch,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_fetch,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_doe,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata
);
    logic accept, enter_t1, finish, op_write;

    mbc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .bus_ready(bus_ready),
        .idle     (req_ready),
        .accept   (accept),
        .enter_t1 (enter_t1),
        .finish   (finish)
    );

    mbc_bus_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .enter_t1 (enter_t1),
        .finish   (finish),
        .req_write(req_write),
        .req_fetch(req_fetch),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_fetch(bus_fetch),
        .bus_doe  (bus_doe),
        .op_write (op_write)
    );

    mbc_rsp #(.DW(DW)) u_rsp (
        .clk      (clk),
        .rst_n    (rst_n),
        .finish   (finish),
        .op_write (op_write),
        .bus_rdata(bus_rdata),
        .rsp_done (rsp_done),
        .rsp_rdata(rsp_rdata)
    );
endmodule

// File: rtl/mbc_chk.sv
module mbc_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          rsp_done,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          bus_fetch,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_doe,
    input logic          bus_ready
);
    // R4 / R6: read and write strobes never overlap
    p_rw_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R5: fetch only accompanies a read
    p_fetch_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fetch |-> bus_rd);

    // R6: the output enable only accompanies a write, and data is zero without it
    p_doe_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> bus_wr);
    p_wdata_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_doe |-> (bus_wdata == '0));

    // R3: the address holds while a strobe stays active
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && $past(bus_rd || bus_wr)) |-> $stable(bus_addr));

    // R2: no acceptance while a strobe is active
    p_busy_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> !req_ready);

    // R8: done is a single-cycle pulse taken with ready while a strobe is up
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (bus_ready && (bus_rd || bus_wr)));

    // R9: strobes are released and the controller is idle after completion
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!bus_rd && !bus_wr && !bus_doe && req_ready));

    // R7: without ready, an active T2 continues
    p_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && $past(bus_rd || bus_wr) && !bus_ready)
            |=> (bus_rd || bus_wr));
endmodule

bind mem_bus_ctrl mbc_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .rsp_done (rsp_done),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_fetch(bus_fetch),
    .bus_wdata(bus_wdata),
    .bus_doe  (bus_doe),
    .bus_ready(bus_ready)
);

// File: tb/mem_bus_ctrl_tb.sv
module mem_bus_ctrl_tb;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_rd, bus_wr, bus_fetch, bus_doe;
    logic [DW-1:0] bus_wdata;
    logic          bus_ready = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] exp_rd = '0;

    always #5 clk = ~clk;

    mem_bus_ctrl #(.AW(AW), .DW(DW)) u_dut (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] ctl_exp(logic wr, logic fe, logic act);
        // {rd, wr, fetch, doe}
        if (!act) return 4'b0000;
        return {!wr, wr, fe && !wr, wr};
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic txn(logic wr, logic fe, logic [AW-1:0] a, logic [DW-1:0] d,
                       int nwait, logic noise);
        logic [DW-1:0] rdv;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_fetch = fe;
        req_addr = a; req_wdata = d;
        #1 chk("R2 ready in idle", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = noise; req_addr = ~a; req_wdata = ~d; req_write = ~wr;
        #1;
        chk("R3 address in setup", 64'(bus_addr), 64'(a));
        chk("R3 strobes low in setup", 64'({bus_rd, bus_wr, bus_fetch, bus_doe}), 64'd0);
        chk("R2 busy not ready", 64'(req_ready), 64'd0);
        @(negedge clk);
        bus_ready = 1'b1; // R7: ready noise during T1
        #1;
        chk(wr ? "R6 write strobes T1" : (fe ? "R5 fetch strobes T1" : "R4 read strobes T1"),
            64'({bus_rd, bus_wr, bus_fetch, bus_doe}), 64'(ctl_exp(wr, fe, 1'b1)));
        chk("R6 wdata in T1", 64'(bus_wdata), wr ? 64'(d) : 64'd0);
        chk("R7 no done in T1", 64'(rsp_done), 64'd0);
        for (int k = 0; k <= nwait; k++) begin
            @(negedge clk);
            bus_ready = (k == nwait);
            rdv = $urandom;
            bus_rdata = rdv;
            #1;
            chk("R2 address unaffected by busy request", 64'(bus_addr), 64'(a));
            chk("R7 strobes held in T2", 64'({bus_rd, bus_wr, bus_fetch, bus_doe}),
                64'(ctl_exp(wr, fe, 1'b1)));
            chk("R8 done only at completing T2", 64'(rsp_done), 64'(k == nwait));
            if (k == nwait && !wr) begin
                chk("R8 read data at done", 64'(rsp_rdata), 64'(rdv));
                exp_rd = rdv;
            end
        end
        @(negedge clk);
        bus_ready = 1'b0; req_valid = 1'b0; bus_rdata = $urandom;
        #1;
        chk("R9 released after completion", 64'({bus_rd, bus_wr, bus_fetch, bus_doe, rsp_done}), 64'd0);
        chk("R9 idle after completion", 64'(req_ready), 64'd1);
        chk("R6 wdata zero after write", 64'(bus_wdata), 64'd0);
        chk("R8 result held", 64'(rsp_rdata), 64'(exp_rd));
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
                summary();
            end
        end
    end

    initial begin
        void'($urandom(32'h1234_abcd));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 strobes after reset", 64'({bus_rd, bus_wr, bus_fetch, bus_doe, rsp_done}), 64'd0);
        chk("R1 ready after reset", 64'(req_ready), 64'd1);
        chk("R1 address after reset", 64'(bus_addr), 64'd0);
        chk("R1 rdata after reset", 64'(rsp_rdata), 64'd0);
        // directed corners
        txn(1'b0, 1'b0, 32'h0000_0010, 32'h0, 0, 1'b0);          // R4 plain read, no wait
        txn(1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0, 3, 1'b1);          // R5 fetch with waits
        txn(1'b1, 1'b1, 32'h8000_0000, 32'hDEAD_BEEF, 0, 1'b1);  // R5 fetch flag on write ignored
        txn(1'b1, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 5, 1'b0);  // R6 write, long wait
        txn(1'b0, 1'b0, 32'h1234_5678, 32'h0, 1, 1'b1);          // R7 one wait
        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r = $urandom;
            txn(r[0], r[1], $urandom, $urandom, int'(r[4:2]), r[5]);
            if (r[6]) repeat (int'(r[8:7])) @(negedge clk);
        end
        summary();
    end
endmodule